// File: doc/BRIEF.md
# Chainable Six-Channel Double-Edge PWM Unit

This block produces six pulse-width-modulated outputs from one shared period counter. Every channel has its own rise position and fall position inside the period, so both edges of each pulse can be placed freely. A configuration write never lands in the running settings. It goes into a shadow copy. Every shadow value (the period and all twelve edge positions) moves into the working set in a single step. That step happens only at a period boundary, and only after a transfer has been requested. A period therefore never runs with a mixture of old and new settings.

Several units can be chained. In master mode a unit arms its transfer from a local request strobe and ignores the chain inputs. In slave mode it does two things from the chain inputs. A pulse on `sync_in` restarts its counter, and a pulse on `xfer_in` arms its transfer. In either mode a unit drives `sync_out` at a programmable count and `xfer_out` just after each commit, so it can act as master for the next unit in the chain. A per-edge enable mask chooses which edge matches raise a flag.

There are two small state machines. The timebase machine has the states TB_HALT and TB_RUN. It goes from TB_HALT to TB_RUN when `run_en` is high, and from TB_RUN back to TB_HALT when `run_en` is low. The transfer machine has the states XF_IDLE and XF_ARMED. It goes from XF_IDLE to XF_ARMED on an arm event, and from XF_ARMED back to XF_IDLE on a period boundary. That second transition is the commit.

Top module: `pwm_chain_unit`

## Requirements
- R1: After reset, all six PWM outputs, all edge flags, `sync_out` and `xfer_out` are low. The counter is halted at zero and every shadow and active value is zero.
- R2: In TB_RUN the counter steps by one on each clock. It goes to zero on the edge after it equals the active period. In TB_HALT it holds zero. Dropping `run_en` in TB_RUN returns the counter to zero on the next edge.
- R3: Channel i output (`pwm_out[i]`) is high exactly while running with rise ≤ count < fall. If rise ≥ fall, the output stays low.
- R4: `edge_flag[2i]` is high while running when the count equals the active rise of channel i and `irq_en[2i]` is set. `edge_flag[2i+1]` does the same for the fall position, gated by `irq_en[2i+1]`.
- R5: A write changes only the shadow copy. At a boundary, a commit moves all shadow values into the active set at once, and only when the transfer machine is in XF_ARMED. A boundary is a counter wrap, or in slave mode a `sync_in` pulse, while running. A write in the commit cycle lands in the shadow after the copy.
- R6: In master mode `xfer_req` arms the transfer and `xfer_in` is ignored. In slave mode `xfer_in` arms it and `xfer_req` is ignored. An arm event while already in XF_ARMED is absorbed.
- R7: In slave mode, a `sync_in` pulse while running sets the counter to zero on the next edge, whatever its value. In master mode `sync_in` has no effect.
- R8: `sync_out` is high for the cycle in which the running counter equals `sync_delay`.
- R9: `xfer_out` is high for exactly the one cycle that follows each commit edge.
- R10: A match write whose channel index `match_ch` is 6 or above changes no shadow value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Run request for the timebase |
| slave_mode | input | 1 | 1 = slave (follows chain inputs), 0 = master |
| period_wr | input | 1 | Write strobe for the shadow period |
| period_val | input | CW | Shadow period value (the counter spans 0..period) |
| match_wr | input | 1 | Write strobe for one channel's shadow edges |
| match_ch | input | CHW | Channel index for the match write |
| match_rise | input | CW | Shadow rise position |
| match_fall | input | CW | Shadow fall position |
| xfer_req | input | 1 | Local transfer request (master mode) |
| sync_delay | input | CW | Count at which `sync_out` is pulsed |
| irq_en | input | 2*NCH | Edge flag enables; bit 2i = rise, 2i+1 = fall of channel i |
| sync_in | input | 1 | Chain restart input (slave mode) |
| xfer_in | input | 1 | Chain transfer-enable input (slave mode) |
| pwm_out | output | NCH | PWM outputs |
| edge_flag | output | 2*NCH | Edge match flags |
| sync_out | output | 1 | Delayed sync toward the next unit |
| xfer_out | output | 1 | Transfer-enable toward the next unit |

## Verification
The PWM outputs, edge flags and `sync_out` are combinational decodes of the counter and the active registers, so each one is due in the same cycle the counter holds the relevant value. Any input, whether a write, an arm, a sync or a run change, acts only through registers and becomes visible after the next rising edge. `xfer_out` shows up one cycle after the edge that performed the commit. The bench drives inputs just after the falling edge and compares the outputs 1 ns later against a cycle model. It advances that model once per rising edge from the inputs it has just applied, so every comparison falls inside the cycle in which the result is due.

// File: rtl/pwm_chain_pkg.sv
package pwm_chain_pkg;
    typedef enum logic {TB_HALT, TB_RUN} tb_state_t;
    typedef enum logic {XF_IDLE, XF_ARMED} xf_state_t;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_chain_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic          slave_mode,
    input  logic          sync_in,
    input  logic [CW-1:0] period,
    input  logic [CW-1:0] sync_delay,
    output logic [CW-1:0] cnt,
    output logic          running,
    output logic          boundary,
    output logic          sync_out
);
    tb_state_t st, st_n;
    logic      restart;

    always_comb begin
        st_n = st;
        unique case (st)
            TB_HALT: if (run_en)  st_n = TB_RUN;
            TB_RUN:  if (!run_en) st_n = TB_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= TB_HALT;
        else        st <= st_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        cnt <= '0;
        else if (st != TB_RUN || !run_en)  cnt <= '0;
        else if (restart)                  cnt <= '0;
        else                               cnt <= cnt + 1'b1;
    end

    always_comb begin
        running  = (st == TB_RUN);
        restart  = (cnt == period) || (slave_mode && sync_in);
        boundary = running && restart;
        sync_out = running && (cnt == sync_delay);
    end

    // R2: wrap back to zero after the period value
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cnt == period) |=> (cnt == '0));
    // R2: counter never exceeds the active period
    p_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt <= period));
    // R7: slave sync restarts the counter
    p_sync_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (running && slave_mode && sync_in) |=> (cnt == '0));
endmodule

// File: rtl/pwm_xfer_ctrl.sv
module pwm_xfer_ctrl
    import pwm_chain_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic boundary,
    output logic commit,
    output logic xfer_out
);
    xf_state_t st, st_n;

    always_comb begin
        st_n = st;
        unique case (st)
            XF_IDLE:  if (arm)      st_n = XF_ARMED;
            XF_ARMED: if (boundary) st_n = XF_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= XF_IDLE;
        else        st <= st_n;
    end

    always_comb commit = (st == XF_ARMED) && boundary;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) xfer_out <= 1'b0;
        else        xfer_out <= commit;
    end

    // R9: transfer-enable output is a single-cycle pulse
    p_xfer_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_out |=> !xfer_out);
    // R9: a pulse always follows a boundary
    p_xfer_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_out |-> $past(boundary));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [CW-1:0] rise_in,
    input  logic [CW-1:0] fall_in,
    input  logic          commit,
    input  logic          running,
    input  logic [CW-1:0] cnt,
    input  logic [1:0]    irq_en,
    output logic          pwm,
    output logic [1:0]    flag
);
    logic [CW-1:0] rise_s, fall_s, rise_a, fall_a;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_s <= '0;
            fall_s <= '0;
        end else if (wr_en) begin
            rise_s <= rise_in;
            fall_s <= fall_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_a <= '0;
            fall_a <= '0;
        end else if (commit) begin
            rise_a <= rise_s;
            fall_a <= fall_s;
        end
    end

    always_comb begin
        pwm     = running && (cnt >= rise_a) && (cnt < fall_a);
        flag[0] = running && irq_en[0] && (cnt == rise_a);
        flag[1] = running && irq_en[1] && (cnt == fall_a);
    end

    // R3: inverted edge pair keeps the output low
    p_inverted_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_a >= fall_a) |-> !pwm);
    // R5: active edges move only on a commit
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable({rise_a, fall_a}));
endmodule

// File: rtl/pwm_chain_unit.sv
module pwm_chain_unit
    import pwm_chain_pkg::*;
#(
    parameter int NCH = 6,
    parameter int CW  = 8,
    localparam int CHW = (NCH > 1) ? $clog2(NCH + 1) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             slave_mode,
    input  logic             period_wr,
    input  logic [CW-1:0]    period_val,
    input  logic             match_wr,
    input  logic [CHW-1:0]   match_ch,
    input  logic [CW-1:0]    match_rise,
    input  logic [CW-1:0]    match_fall,
    input  logic             xfer_req,
    input  logic [CW-1:0]    sync_delay,
    input  logic [2*NCH-1:0] irq_en,
    input  logic             sync_in,
    input  logic             xfer_in,
    output logic [NCH-1:0]   pwm_out,
    output logic [2*NCH-1:0] edge_flag,
    output logic             sync_out,
    output logic             xfer_out
);
    logic [CW-1:0] per_s, per_a, cnt;
    logic          running, boundary, commit, arm;

    always_comb arm = slave_mode ? xfer_in : xfer_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         per_s <= '0;
        else if (period_wr) per_s <= period_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      per_a <= '0;
        else if (commit) per_a <= per_s;
    end

    pwm_timebase #(.CW(CW)) u_tb (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .slave_mode(slave_mode),
        .sync_in(sync_in), .period(per_a), .sync_delay(sync_delay),
        .cnt(cnt), .running(running), .boundary(boundary), .sync_out(sync_out)
    );

    pwm_xfer_ctrl u_xf (
        .clk(clk), .rst_n(rst_n), .arm(arm), .boundary(boundary),
        .commit(commit), .xfer_out(xfer_out)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam logic [CHW-1:0] IDX = CHW'(i);
        pwm_channel #(.CW(CW)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .wr_en(match_wr && (match_ch == IDX)),
            .rise_in(match_rise), .fall_in(match_fall),
            .commit(commit), .running(running), .cnt(cnt),
            .irq_en(irq_en[2*i +: 2]),
            .pwm(pwm_out[i]), .flag(edge_flag[2*i +: 2])
        );
    end

    // R5: active period changes only on a commit
    p_period_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(per_a));
    // R1: nothing is driven while halted
    p_halt_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (pwm_out == '0 && edge_flag == '0 && !sync_out));
endmodule

// File: tb/sim_pwm_chain_unit.sv
module sim_pwm_chain_unit;
    localparam int NCH = 6;
    localparam int CW  = 8;
    localparam int CHW = 3;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, run_en, slave_mode, period_wr, match_wr, xfer_req, sync_in, xfer_in;
    logic [CW-1:0] period_val, match_rise, match_fall, sync_delay;
    logic [CHW-1:0] match_ch;
    logic [2*NCH-1:0] irq_en, edge_flag;
    logic [NCH-1:0] pwm_out;
    logic sync_out, xfer_out;

    pwm_chain_unit #(.NCH(NCH), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .slave_mode(slave_mode),
        .period_wr(period_wr), .period_val(period_val), .match_wr(match_wr),
        .match_ch(match_ch), .match_rise(match_rise), .match_fall(match_fall),
        .xfer_req(xfer_req), .sync_delay(sync_delay), .irq_en(irq_en),
        .sync_in(sync_in), .xfer_in(xfer_in), .pwm_out(pwm_out),
        .edge_flag(edge_flag), .sync_out(sync_out), .xfer_out(xfer_out)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string tag = "R3";

    bit m_run, m_armed, m_xo;
    int m_cnt, m_per_s, m_per_a;
    int m_rs[NCH], m_fs[NCH], m_ra[NCH], m_fa[NCH];

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [NCH-1:0] exp_pwm();
        logic [NCH-1:0] v;
        for (int i = 0; i < NCH; i++)
            v[i] = m_run && (m_cnt >= m_ra[i]) && (m_cnt < m_fa[i]);
        return v;
    endfunction

    function automatic logic [2*NCH-1:0] exp_flag();
        logic [2*NCH-1:0] v;
        for (int i = 0; i < NCH; i++) begin
            v[2*i]   = m_run && irq_en[2*i]   && (m_cnt == m_ra[i]);
            v[2*i+1] = m_run && irq_en[2*i+1] && (m_cnt == m_fa[i]);
        end
        return v;
    endfunction

    task automatic cycle();
        bit bnd, arm, com;
        #1;
        check(tag,  32'(pwm_out),   32'(exp_pwm()),  "pwm_out");
        check("R4", 32'(edge_flag), 32'(exp_flag()), "edge_flag");
        check("R8", 32'(sync_out),  32'(m_run && (m_cnt == int'(sync_delay))), "sync_out");
        check("R9", 32'(xfer_out),  32'(m_xo), "xfer_out");
        bnd = m_run && ((m_cnt == m_per_a) || (slave_mode && sync_in));
        arm = slave_mode ? xfer_in : xfer_req;
        com = m_armed && bnd;
        m_xo = com;
        if (m_armed) m_armed = !bnd;
        else         m_armed = arm;
        if (m_run) begin
            if (!run_en) begin m_cnt = 0; m_run = 0; end
            else if ((slave_mode && sync_in) || m_cnt == m_per_a) m_cnt = 0;
            else m_cnt++;
        end else begin
            m_cnt = 0;
            m_run = run_en;
        end
        if (com) begin
            m_per_a = m_per_s;
            for (int i = 0; i < NCH; i++) begin m_ra[i] = m_rs[i]; m_fa[i] = m_fs[i]; end
        end
        if (period_wr) m_per_s = int'(period_val);
        if (match_wr && int'(match_ch) < NCH) begin
            m_rs[int'(match_ch)] = int'(match_rise);
            m_fs[int'(match_ch)] = int'(match_fall);
        end
        @(posedge clk);
        @(negedge clk);
        period_wr = 0; match_wr = 0; xfer_req = 0; xfer_in = 0; sync_in = 0;
    endtask

    task automatic wr_match(int ch, int r, int f);
        match_wr = 1; match_ch = CHW'(ch); match_rise = CW'(r); match_fall = CW'(f);
        cycle();
    endtask

    task automatic wr_period(int p);
        period_wr = 1; period_val = CW'(p);
        cycle();
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) cycle();
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        rst_n = 0; run_en = 0; slave_mode = 0; period_wr = 0; match_wr = 0;
        xfer_req = 0; sync_in = 0; xfer_in = 0; period_val = 0; match_rise = 0;
        match_fall = 0; match_ch = 0; sync_delay = 8'hFF; irq_en = '1;
        m_run = 0; m_armed = 0; m_xo = 0; m_cnt = 0; m_per_s = 0; m_per_a = 0;
        for (int i = 0; i < NCH; i++) begin m_rs[i] = 0; m_fs[i] = 0; m_ra[i] = 0; m_fa[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        check("R1", 32'(pwm_out), 0, "pwm_out after reset");
        check("R1", 32'(edge_flag), 0, "edge_flag after reset");
        check("R1", 32'(sync_out), 0, "sync_out after reset");
        check("R1", 32'(xfer_out), 0, "xfer_out after reset");

        // R5: shadow writes stay invisible until a requested commit
        tag = "R5";
        wr_period(9);
        wr_match(0, 2, 5);
        wr_match(1, 6, 3);          // R3: inverted pair
        wr_match(2, 0, 1);
        wr_match(3, 0, 10);
        run_en = 1;
        idle(15);
        xfer_req = 1; cycle();
        tag = "R2";
        idle(30);

        // R10: out-of-range channel writes are dropped
        tag = "R10";
        wr_match(6, 1, 8);
        wr_match(7, 0, 9);
        xfer_req = 1; cycle();
        idle(25);

        // R6: slave ignores local request, honours chain input
        tag = "R6";
        slave_mode = 1;
        wr_match(4, 3, 7);
        xfer_req = 1; cycle();
        idle(22);
        xfer_in = 1; cycle();
        idle(22);

        // R7: sync restarts the slave counter mid-period
        tag = "R7";
        idle(4);
        sync_in = 1; cycle();
        idle(6);
        sync_in = 1; cycle();
        idle(12);
        slave_mode = 0;
        idle(3);
        sync_in = 1; cycle();       // master ignores it
        idle(12);

        // R8: sync output at a programmed count
        tag = "R8";
        sync_delay = 4;
        idle(25);
        run_en = 0; idle(3); run_en = 1;   // R2: halt returns count to zero
        idle(12);

        // random phase
        tag = "R3";
        for (int n = 0; n < 6000; n++) begin
            if ($urandom_range(99) < 3)  begin period_wr = 1; period_val = CW'($urandom_range(14, 1)); end
            if ($urandom_range(99) < 12) begin
                match_wr = 1; match_ch = CHW'($urandom_range(7));
                match_rise = CW'($urandom_range(16)); match_fall = CW'($urandom_range(16));
            end
            if ($urandom_range(99) < 6) xfer_req = 1;
            if ($urandom_range(99) < 6) xfer_in = 1;
            if ($urandom_range(99) < 4) sync_in = 1;
            if ($urandom_range(999) < 5) slave_mode = ~slave_mode;
            if ($urandom_range(99) < 1) run_en = ~run_en;
            else if (!run_en && $urandom_range(9) < 3) run_en = 1;
            if ($urandom_range(99) < 2) sync_delay = CW'($urandom_range(15));
            if ($urandom_range(99) < 2) irq_en = (2*NCH)'($urandom);
            cycle();
        end

        done = 1;
        summary();
        $finish;
    end
endmodule